// File: doc/BRIEF.md
# Serial EEPROM Command Front End

This block is the slave side of a four-wire serial memory link. It holds a 512-byte array as on-chip storage and decodes byte-wide instructions clocked in on the data input. The supported instructions read the array, write the array, read and write a status byte, and set or clear a write-enable latch. A host drives chip select low, shifts an opcode and any address and data bytes in on SI, and receives read data on SO.

Writes are guarded three ways: by the write-enable latch, by a two-bit block-protect field in the status byte, and by an active-low write-protect input. A write collects up to one page of bytes into a buffer. When chip select rises on a byte boundary, the page is committed in a self-timed cycle that lasts a fixed number of system-clock cycles. While that cycle runs, a busy flag shows in the status byte.

All serial pins are sampled by the system clock, so each SCK phase must last at least three system-clock periods.

Top module: `spiEeprom`

## Requirements
- R1: Both idle clock levels work: SCK low at select (mode 0) and SCK high at select (mode 3). SI is taken on each rising SCK edge, MSB first. SO changes after falling SCK edges, so it is valid at the next rising edge.
- R2: Opcodes: 0x06 sets the latch, 0x04 clears the latch, 0x05 reads status, 0x01 writes status, 0x03 reads the array and 0x02 writes the array. For the read and write opcodes, bit 3 carries address bit 8, so the read opcodes are 0x03/0x0B and the write opcodes are 0x02/0x0A. The opcode is followed by one low-address byte. Any other opcode is ignored and returns nothing.
- R3: The status byte reads {4'b0000, protect[1:0], latch, busy}: bit 0 is busy, bit 1 is the write-enable latch, and bits 3:2 are the protect field. After reset it reads 0x00, and it repeats for as long as the clock keeps running.
- R4: The latch-set opcode takes effect only when chip select rises after exactly its eight bits. An array or status write issued while the latch is clear changes nothing.
- R5: A status write sent in the same select frame as the latch-set opcode is ignored.
- R6: The protect field blocks writes to a region: 00 blocks none, 01 blocks 0x180–0x1FF, 10 blocks 0x100–0x1FF and 11 blocks 0x000–0x1FF. A blocked write leaves the array unchanged and the latch set.
- R7: If the write-protect input is low when chip select rises, no write starts. Taking it low once a cycle has started does not stop that cycle.
- R8: A page write stores bytes from the start address upward, wrapping inside its 16-byte page, so a byte beyond 16 overwrites an earlier one. The write is committed only if chip select rises on a byte boundary after at least one data byte; otherwise the whole write is dropped.
- R9: A committed write holds busy at 1 for WRITE_CYCLES system clocks and clears the latch when it ends. While busy, only the status-read opcode is served; array reads return nothing.
- R10: A read streams bytes from the start address upward and wraps from 0x1FF to 0x000.
- R11: The SO enable is low whenever chip select is high and whenever the current instruction returns no data.
- R12: After reset, no instruction is accepted until chip select has been seen high and then low.
- R13: The latch-clear opcode clears the write-enable latch when chip select rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock for pin sampling and the write timer |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| wpN | input | 1 | Active-low write protect |
| so | output | 1 | Serial data out |
| soOe | output | 1 | Output enable for so; low means high impedance |

## Verification
The bench builds the block with a 16-byte page and WRITE_CYCLES set to 600. A status read, and a rejected array read, both fit inside one write cycle, so the busy flag and the refusal of reads while busy can be seen directly. The cycle still ends early enough that many commits, protect-field changes and page-wrap writes fit in one run. The page size matches the default, so wrap and overwrite are checked at the page width the block ships with.

// File: rtl/eeSpiPkg.sv
package eeSpiPkg;
  localparam int ADDR_W = 9;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int A8_POS = 3;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [3:0] {
    S_IDLE, S_OPC, S_ADDR, S_RDAT, S_WDAT, S_SRD, S_SWR, S_WEN, S_WDI, S_SKIP
  } ctlState_e;

  typedef struct packed {
    logic              setAddr;
    logic [ADDR_W-1:0] addrVal;
    logic              bufByte;
    logic [7:0]        byteVal;
    logic              nextAddr;
    logic              commitArr;
    logic              commitSts;
    logic              wrenDone;
    logic              wrdiDone;
  } dpStrobe_t;

  function automatic logic isProt(input logic [ADDR_W-1:0] a, input logic [1:0] bp);
    case (bp)
      2'b00:   return 1'b0;
      2'b01:   return a[ADDR_W-1 -: 2] == 2'b11;
      2'b10:   return a[ADDR_W-1];
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/eeSpiCtrl.sv
module eeSpiCtrl
  import eeSpiPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sck,
  input  logic       si,
  input  logic       busy,
  input  logic [7:0] rdByte,
  input  logic [7:0] stsByte,
  output dpStrobe_t  stb,
  output logic       so,
  output logic       soOe
);
  logic [2:0] s1;
  logic [1:0] s2;
  ctlState_e  state;
  logic [2:0] bitCnt;
  logic [6:0] inByte;
  logic [7:0] lastByte;
  logic       gotByte, a8, rdMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= {csN, sck, si};
      s2 <= s1[2:1];
    end
  end

  logic csHigh, csFall, csRise, sckRise, sckFall, byteDone;
  logic [7:0] newByte, opMasked;
  assign csHigh   = s1[2];
  assign csFall   = !s1[2] && s2[1];
  assign csRise   = s1[2] && !s2[1];
  assign sckRise  = !csHigh && s1[1] && !s2[0];
  assign sckFall  = !csHigh && !s1[1] && s2[0];
  assign newByte  = {inByte, s1[0]};
  assign byteDone = sckRise && (bitCnt == 3'd7);
  assign opMasked = newByte & ~(8'h01 << A8_POS);

  always_comb begin
    stb          = '0;
    stb.addrVal  = {a8, newByte};
    stb.byteVal  = csRise ? lastByte : newByte;
    if (byteDone) begin
      stb.setAddr  = (state == S_ADDR);
      stb.bufByte  = (state == S_WDAT);
      stb.nextAddr = (state == S_RDAT);
    end
    if (csRise) begin
      stb.commitArr = (state == S_WDAT) && gotByte && (bitCnt == 3'd0);
      stb.commitSts = (state == S_SWR) && gotByte && (bitCnt == 3'd0);
      stb.wrenDone  = (state == S_WEN);
      stb.wrdiDone  = (state == S_WDI);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      bitCnt   <= '0;
      inByte   <= '0;
      lastByte <= '0;
      gotByte  <= 1'b0;
      a8       <= 1'b0;
      rdMode   <= 1'b0;
    end else if (csHigh) begin
      state <= S_IDLE;
    end else if (csFall && state == S_IDLE) begin
      state   <= S_OPC;
      bitCnt  <= '0;
      gotByte <= 1'b0;
    end else if (sckRise && state != S_IDLE) begin
      bitCnt <= bitCnt + 3'd1;
      inByte <= newByte[6:0];
      if (state == S_WEN || state == S_WDI) state <= S_SKIP;
      if (byteDone) begin
        lastByte <= newByte;
        case (state)
          S_OPC: begin
            a8 <= newByte[A8_POS];
            if (busy && newByte != OP_RDSR)  state <= S_SKIP;
            else if (newByte == OP_WREN)     state <= S_WEN;
            else if (newByte == OP_WRDI)     state <= S_WDI;
            else if (newByte == OP_RDSR)     state <= S_SRD;
            else if (newByte == OP_WRSR)     state <= S_SWR;
            else if (opMasked == OP_READ)  begin state <= S_ADDR; rdMode <= 1'b1; end
            else if (opMasked == OP_WRITE) begin state <= S_ADDR; rdMode <= 1'b0; end
            else                             state <= S_SKIP;
          end
          S_ADDR: state <= rdMode ? S_RDAT : S_WDAT;
          S_WDAT, S_SWR: gotByte <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) so <= 1'b0;
    else if (sckFall && (state == S_RDAT || state == S_SRD))
      so <= (state == S_SRD) ? stsByte[~bitCnt] : rdByte[~bitCnt];
  end

  assign soOe = !csHigh && (state == S_RDAT || state == S_SRD);

  a_r11_oe_drops: assert property (@(posedge clk) disable iff (!rstN)
    csRise |=> !soOe);
  a_r9_busy_refuses: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_OPC && byteDone && busy && newByte != OP_RDSR) |=> state == S_SKIP);
endmodule

// File: rtl/eeSpiDp.sv
module eeSpiDp
  import eeSpiPkg::*;
#(
  parameter int PAGE_W       = 4,
  parameter int WRITE_CYCLES = 2000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wpN,
  input  dpStrobe_t  stb,
  output logic       busy,
  output logic [7:0] rdByte,
  output logic [7:0] stsByte
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int TMR_W      = $clog2(WRITE_CYCLES + 1);

  logic [7:0]            mem     [DEPTH];
  logic [7:0]            pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask;
  logic [PAGE_W-1:0]     wOff;
  logic [ADDR_W-1:0]     ptr;
  logic [TMR_W-1:0]      timer;
  logic [1:0]            bp;
  logic                  wel, arrCycle;
  logic                  arrOk, stsOk;

  assign arrOk = stb.commitArr && !busy && wel && wpN && (|mask) && !isProt(ptr, bp);
  assign stsOk = stb.commitSts && !busy && wel && wpN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      for (int i = 0; i < PAGE_BYTES; i++) pageBuf[i] <= 8'h00;
      mask     <= '0;
      wOff     <= '0;
      ptr      <= '0;
      timer    <= '0;
      bp       <= 2'b00;
      wel      <= 1'b0;
      busy     <= 1'b0;
      arrCycle <= 1'b0;
    end else begin
      if (stb.setAddr) begin
        ptr  <= stb.addrVal;
        wOff <= stb.addrVal[PAGE_W-1:0];
        mask <= '0;
      end
      if (stb.nextAddr) ptr <= ptr + ADDR_W'(1);
      if (stb.bufByte) begin
        pageBuf[wOff] <= stb.byteVal;
        mask[wOff]    <= 1'b1;
        wOff          <= wOff + PAGE_W'(1);
      end
      if (stb.wrenDone && !busy) wel <= 1'b1;
      if (stb.wrdiDone && !busy) wel <= 1'b0;
      if (arrOk || stsOk) begin
        busy     <= 1'b1;
        arrCycle <= arrOk;
        timer    <= '0;
      end
      if (stsOk) bp <= stb.byteVal[3:2];
      if (busy) begin
        timer <= timer + TMR_W'(1);
        if (timer == TMR_W'(WRITE_CYCLES - 1)) begin
          busy <= 1'b0;
          wel  <= 1'b0;
          if (arrCycle)
            for (int i = 0; i < PAGE_BYTES; i++)
              if (mask[i]) mem[{ptr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pageBuf[i];
        end
      end
    end
  end

  assign rdByte  = mem[ptr];
  assign stsByte = {4'b0000, bp, wel, busy};

  a_r4_latch_before_cycle: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(wel));
  a_r7_wp_high_at_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(wpN));
  a_r6_page_unprotected: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busy) && arrCycle) |-> !isProt(ptr, bp));
  a_r9_latch_clears: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !wel);
endmodule

// File: rtl/spiEeprom.sv
module spiEeprom
  import eeSpiPkg::*;
#(
  parameter int PAGE_W       = 4,
  parameter int WRITE_CYCLES = 2000
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sck,
  input  logic si,
  input  logic wpN,
  output logic so,
  output logic soOe
);
  dpStrobe_t  stb;
  logic       busy;
  logic [7:0] rdByte, stsByte;

  eeSpiCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si),
    .busy(busy), .rdByte(rdByte), .stsByte(stsByte),
    .stb(stb), .so(so), .soOe(soOe)
  );

  eeSpiDp #(.PAGE_W(PAGE_W), .WRITE_CYCLES(WRITE_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .wpN(wpN), .stb(stb),
    .busy(busy), .rdByte(rdByte), .stsByte(stsByte)
  );
endmodule

// File: tb/spiEeprom_tb.sv
module spiEeprom_tb;
  localparam int CLK_PERIOD = 10;
  localparam int H  = 6;
  localparam int WC = 600;

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b0, sck = 1'b0, si = 1'b0, wpN = 1'b1;
  logic so, soOe;

  spiEeprom #(.PAGE_W(4), .WRITE_CYCLES(WC)) u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si),
    .wpN(wpN), .so(so), .soOe(soOe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, oeSeen = 0, oeBad = 0;
  logic [7:0] txQ[$];
  logic [7:0] rxQ[$];
  logic [7:0] dq[$];
  logic [7:0] mdl[512];
  logic       mWel = 1'b0;
  logic [1:0] mBp = 2'b00;
  logic       pend = 1'b0;
  logic [2:0] csHist = 3'b000;
  logic [7:0] sv;

  always @(posedge clk) begin
    csHist <= {csHist[1:0], csN};
    if (rstN && csHist == 3'b111 && soOe) oeBad++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit prot(input int a, input logic [1:0] b);
    case (b)
      2'b00: return 0;
      2'b01: return a >= 'h180;
      2'b10: return a >= 'h100;
      default: return 1;
    endcase
  endfunction

  task automatic frame(input int nBits, input bit m3, input bit keepCs);
    logic [7:0] cur = 8'h00;
    rxQ.delete();
    oeSeen = 0;
    @(negedge clk) sck = m3;
    repeat (2) @(negedge clk);
    if (!keepCs) csN = 1'b0;
    repeat (H) @(negedge clk);
    for (int b = 0; b < nBits; b++) begin
      if (m3) sck = 1'b0;
      si = (b / 8 < txQ.size()) ? txQ[b / 8][7 - b % 8] : 1'b0;
      repeat (H) @(negedge clk);
      cur = {cur[6:0], so};
      if (soOe) oeSeen++;
      sck = 1'b1;
      repeat (H) @(negedge clk);
      if (!m3) sck = 1'b0;
      if (b % 8 == 7) rxQ.push_back(cur);
    end
    repeat (H) @(negedge clk);
    if (!keepCs) csN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wren(input bit m3);
    txQ = {8'h06};
    frame(8, m3, 0);
    mWel = 1'b1;
  endtask

  task automatic rdsr(output logic [7:0] v);
    txQ = {8'h05};
    frame(16, 0, 0);
    v = rxQ[1];
  endtask

  function automatic logic [7:0] expSts(input bit bsy);
    return {4'b0000, mBp, mWel, bsy};
  endfunction

  task automatic doWrite(input int addr, input int extra);
    txQ = {8'h02 | (8'(addr >> 8) << 3), 8'(addr)};
    foreach (dq[i]) txQ.push_back(dq[i]);
    frame(8 * txQ.size() + extra, 0, 0);
    chk(oeSeen == 0, "R11 write frame oe", oeSeen, 0);
    pend = (extra == 0) && mWel && wpN && !prot(addr, mBp) && (dq.size() > 0);
    if (pend)
      foreach (dq[i]) mdl[(addr & 'h1F0) | ((addr + i) & 'hF)] = dq[i];
  endtask

  task automatic doWrsr(input logic [7:0] v);
    txQ = {8'h01, v};
    frame(16, 0, 0);
    pend = mWel && wpN;
    if (pend) mBp = v[3:2];
  endtask

  task automatic settle();
    repeat (WC + 20) @(negedge clk);
    if (pend) mWel = 1'b0;
    pend = 1'b0;
  endtask

  task automatic readChk(input int addr, input int n, input bit m3, input string req);
    txQ = {8'h03 | (8'(addr >> 8) << 3), 8'(addr)};
    frame(8 * (2 + n), m3, 0);
    for (int i = 0; i < n; i++)
      chk(rxQ[2 + i] == mdl[(addr + i) % 512], req, rxQ[2 + i], mdl[(addr + i) % 512]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) mdl[i] = 8'hFF;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(soOe == 1'b0, "R11 reset oe", soOe, 0);
    // R12: select held low since reset, a status read must not be served
    txQ = {8'h05};
    frame(16, 0, 1);
    chk(oeSeen == 0, "R12 no select edge", oeSeen, 0);
    csN = 1'b1;
    repeat (4) @(negedge clk);
    rdsr(sv); chk(sv == 8'h00, "R3 reset status", sv, 0);

    dq = {8'hAA}; doWrite('h010, 0); settle();
    readChk('h010, 1, 0, "R4 write without latch");

    txQ = {8'hFF};
    frame(16, 0, 0);
    chk(oeSeen == 0, "R2 unknown opcode", oeSeen, 0);

    wren(0); rdsr(sv); chk(sv == expSts(0), "R4 latch set", sv, expSts(0));
    txQ = {8'h04}; frame(8, 0, 0); mWel = 1'b0;
    rdsr(sv); chk(sv == 8'h00, "R13 latch clear", sv, 0);

    txQ = {8'h06, 8'h01, 8'h0C}; frame(24, 0, 0);
    rdsr(sv); chk(sv == 8'h00, "R5 same frame status write", sv, 0);

    wren(0); dq = {8'hC3}; doWrite('h1FF, 0); settle();
    wren(1); dq = {8'h3C}; doWrite('h000, 0); settle();
    readChk('h1FE, 4, 0, "R10 read wrap");

    wren(0); doWrsr(8'h04);
    rdsr(sv); chk(sv == expSts(1), "R9 busy in status cycle", sv, expSts(1));
    settle();
    rdsr(sv); chk(sv == expSts(0), "R3 protect field", sv, expSts(0));

    wren(0); dq = {8'h55}; doWrite('h190, 0);
    rdsr(sv); chk(sv == expSts(0), "R6 blocked keeps latch", sv, expSts(0));
    readChk('h190, 1, 0, "R6 blocked 01");

    dq = {8'h11, 8'h22, 8'h33, 8'h44}; doWrite('h17E, 0);
    rdsr(sv); chk(sv == expSts(1), "R9 busy after commit", sv, expSts(1));
    txQ = {8'h0B, 8'h70, 8'h00}; frame(24, 0, 0);
    chk(oeSeen == 0, "R9 read refused while busy", oeSeen, 0);
    settle();
    rdsr(sv); chk(sv == expSts(0), "R9 latch cleared at end", sv, expSts(0));
    readChk('h170, 16, 1, "R8 R1 page wrap mode 3");

    wren(0); wpN = 1'b0; dq = {8'h5A}; doWrite('h020, 0);
    rdsr(sv); chk(sv == expSts(0), "R7 wp blocks start", sv, expSts(0));
    wpN = 1'b1; doWrite('h020, 0);
    wpN = 1'b0; settle(); wpN = 1'b1;
    readChk('h020, 1, 0, "R7 wp low during cycle");

    wren(0); dq = {8'h77}; doWrite('h030, 3);
    rdsr(sv); chk(sv == expSts(0), "R8 partial byte dropped", sv, expSts(0));
    readChk('h030, 1, 0, "R8 partial byte array");

    dq.delete();
    for (int i = 0; i < 17; i++) dq.push_back(8'(8'h80 + i));
    doWrite('h043, 0); settle();
    readChk('h040, 16, 0, "R8 overflow overwrites");

    wren(0); doWrsr(8'h08); settle();
    wren(0); dq = {8'h99}; doWrite('h100, 0);
    dq = {8'h66}; doWrite('h0F0, 0); settle();
    readChk('h0F0, 1, 0, "R6 unblocked below 100");
    readChk('h100, 1, 0, "R6 blocked 10");

    wren(0); doWrsr(8'h0C); settle();
    wren(0); dq = {8'h00}; doWrite('h000, 0); settle();
    readChk('h000, 1, 1, "R6 blocked 11");

    chk(oeBad == 0, "R11 oe while deselected", oeBad, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule